// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Bridge

This block joins a 16-bit processor that announces each bus transaction through a small status code to a family of 8-bit peripherals that answer an interrupt acknowledge only when they see an opcode-fetch strobe together with read and I/O-request strobes, all active low. When the processor presents the vectored-acknowledge code, the bridge runs the peripheral-side handshake, stalls the processor through a ready line, samples the 8-bit vector the interrupting device places on the low data lines and hands back a 16-bit identifier word built from that vector and a status byte.

The processor side marks each new transaction with a one-cycle valid pulse alongside the code. The non-maskable acknowledge code is recognised separately and only raises a one-cycle flag; the non-vectored acknowledge code and every other code leave the peripheral side idle and the identifier untouched. Codes that arrive while an acknowledge handshake is still running are dropped.

Top module: `viack_bridge`

## Requirements
- R1: After reset, m1_n, rd_n and iorq_n are high, cpu_ready is high, ident_word is 16'h0000 and ident_valid and nmi_ack are low.
- R2: A txn_valid pulse with txn_code 4'b0111 while idle starts an acknowledge: in the next cycle m1_n and cpu_ready are low while rd_n and iorq_n are still high.
- R3: One cycle after m1_n falls, rd_n and iorq_n fall together and stay low for exactly HOLD_CYC cycles (default 2) while m1_n stays low.
- R4: periph_data is sampled at the clock edge that ends the rd_n/iorq_n window, and m1_n, rd_n and iorq_n all rise at that same edge.
- R5: The identifier is {status_byte, vector}: status_byte in bits 15:8, the sampled periph_data in bits 7:0; ident_valid is high for exactly the one cycle after the word is updated.
- R6: cpu_ready stays low from the cycle after the acknowledge is accepted until the vector is sampled, and is high again in the cycle after that.
- R7: A txn_valid pulse with txn_code NMI_CODE (default 4'b0101) while idle raises nmi_ack for exactly one cycle and leaves all strobes high, cpu_ready high and ident_word unchanged.
- R8: A txn_valid pulse with the non-vectored code NVI_CODE (default 4'b0110) or any code other than 4'b0111 and NMI_CODE produces no strobe, no nmi_ack, no ident_valid and no change of ident_word; txn_code is ignored while txn_valid is low.
- R9: A txn_valid pulse arriving while an acknowledge is in progress is ignored: the running handshake is neither restarted nor extended and no nmi_ack is raised.
- R10: Eight distinct vectors, one per serial channel, each reach ident_word bits 7:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | One-cycle pulse: txn_code holds a new transaction code |
| txn_code | input | 4 | Processor transaction status code |
| periph_data | input | 8 | Low data lines driven by the peripherals |
| status_byte | input | 8 | Byte placed in identifier bits 15:8 |
| m1_n | output | 1 | Active-low opcode-fetch strobe to peripherals |
| rd_n | output | 1 | Active-low read strobe to peripherals |
| iorq_n | output | 1 | Active-low I/O request strobe to peripherals |
| cpu_ready | output | 1 | Low while the processor cycle must stall |
| ident_word | output | 16 | Identifier word returned to the processor |
| ident_valid | output | 1 | One-cycle pulse after ident_word is updated |
| nmi_ack | output | 1 | One-cycle flag for a non-maskable acknowledge |

## Verification
The vectored code is driven with eight different vector and status-byte pairs while the data lines carry a decoy value until the last window cycle, which separates sampling at the closing edge from sampling any earlier, and distinct vectors expose swapped or stuck bits. The non-maskable code, the non-vectored code and an unrelated code are each applied alone to tell the three decode branches apart, and the vectored code is held on txn_code with txn_valid low to show that the valid pulse gates decoding. Codes injected in the middle of a running handshake show whether the sequencer restarts, stretches or leaks an nmi flag.

// File: rtl/viack_pkg.sv
package viack_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_VI   = 2'd1,
        KIND_NMI  = 2'd2
    } txn_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_e;

endpackage

// File: rtl/viack_decode.sv
module viack_decode
    import viack_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] VI_CODE  = 4'b0111,
    parameter logic [CODE_W-1:0] NMI_CODE = 4'b0101,
    parameter logic [CODE_W-1:0] NVI_CODE = 4'b0110
) (
    input  logic              txn_valid,
    input  logic [CODE_W-1:0] txn_code,
    output txn_kind_e         kind
);
    // The non-vectored code is matched first so it can never start a
    // handshake, even if it is configured to overlap another code.
    always_comb begin
        kind = KIND_NONE;
        if (txn_valid) begin
            if (txn_code == NVI_CODE) begin
                kind = KIND_NONE;
            end else if (txn_code == VI_CODE) begin
                kind = KIND_VI;
            end else if (txn_code == NMI_CODE) begin
                kind = KIND_NMI;
            end
        end
    end
endmodule

// File: rtl/viack_seq.sv
module viack_seq
    import viack_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  txn_kind_e kind,
    output logic      m1_n,
    output logic      rd_n,
    output logic      iorq_n,
    output logic      ready,
    output logic      cap_now,
    output logic      nmi_pulse
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             m1_n;
        logic             rd_n;
        logic             iorq_n;
        logic             ready;
        logic             nmi;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:  SEQ_IDLE,
        cnt:    '0,
        m1_n:   1'b1,
        rd_n:   1'b1,
        iorq_n: 1'b1,
        ready:  1'b1,
        nmi:    1'b0
    };

    seq_regs_t seq_d, seq_q;
    logic      cap_d;

    always_comb begin
        seq_d     = seq_q;
        seq_d.nmi = 1'b0;
        cap_d     = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (kind == KIND_VI) begin
                    seq_d.state = SEQ_LEAD;
                    seq_d.m1_n  = 1'b0;
                    seq_d.ready = 1'b0;
                end else if (kind == KIND_NMI) begin
                    seq_d.nmi = 1'b1;
                end
            end
            SEQ_LEAD: begin
                seq_d.state  = SEQ_HOLD;
                seq_d.rd_n   = 1'b0;
                seq_d.iorq_n = 1'b0;
                seq_d.cnt    = '0;
            end
            SEQ_HOLD: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.state  = SEQ_IDLE;
                    seq_d.m1_n   = 1'b1;
                    seq_d.rd_n   = 1'b1;
                    seq_d.iorq_n = 1'b1;
                    seq_d.ready  = 1'b1;
                    seq_d.cnt    = '0;
                    cap_d        = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d = SEQ_RESET;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign m1_n      = seq_q.m1_n;
    assign rd_n      = seq_q.rd_n;
    assign iorq_n    = seq_q.iorq_n;
    assign ready     = seq_q.ready;
    assign nmi_pulse = seq_q.nmi;
    assign cap_now   = cap_d;
endmodule

// File: rtl/viack_capture.sv
module viack_capture #(
    parameter int VEC_W  = 8,
    parameter int STAT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_now,
    input  logic [VEC_W-1:0]        vec_in,
    input  logic [STAT_W-1:0]       stat_in,
    output logic [STAT_W+VEC_W-1:0] word,
    output logic                    word_valid
);
    localparam int WORD_W = STAT_W + VEC_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = 1'b0;
        if (cap_now) begin
            cap_d.word  = {stat_in, vec_in};
            cap_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word       = cap_q.word;
    assign word_valid = cap_q.valid;
endmodule

// File: rtl/viack_bridge.sv
module viack_bridge
    import viack_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int VEC_W    = 8,
    parameter int STAT_W   = 8,
    parameter int HOLD_CYC = 2,
    parameter logic [CODE_W-1:0] VI_CODE  = 4'b0111,
    parameter logic [CODE_W-1:0] NMI_CODE = 4'b0101,
    parameter logic [CODE_W-1:0] NVI_CODE = 4'b0110,
    localparam int WORD_W = STAT_W + VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [CODE_W-1:0] txn_code,
    input  logic [VEC_W-1:0]  periph_data,
    input  logic [STAT_W-1:0] status_byte,
    output logic              m1_n,
    output logic              rd_n,
    output logic              iorq_n,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] ident_word,
    output logic              ident_valid,
    output logic              nmi_ack
);
    txn_kind_e kind;
    logic      cap_now;

    viack_decode #(
        .CODE_W   (CODE_W),
        .VI_CODE  (VI_CODE),
        .NMI_CODE (NMI_CODE),
        .NVI_CODE (NVI_CODE)
    ) u_decode (
        .txn_valid (txn_valid),
        .txn_code  (txn_code),
        .kind      (kind)
    );

    viack_seq #(
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .m1_n      (m1_n),
        .rd_n      (rd_n),
        .iorq_n    (iorq_n),
        .ready     (cpu_ready),
        .cap_now   (cap_now),
        .nmi_pulse (nmi_ack)
    );

    viack_capture #(
        .VEC_W  (VEC_W),
        .STAT_W (STAT_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_now    (cap_now),
        .vec_in     (periph_data),
        .stat_in    (status_byte),
        .word       (ident_word),
        .word_valid (ident_valid)
    );
endmodule

// File: rtl/viack_bridge_chk.sv
module viack_bridge_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m1_n,
    input logic              rd_n,
    input logic              iorq_n,
    input logic              cpu_ready,
    input logic [WORD_W-1:0] ident_word,
    input logic              ident_valid,
    input logic              nmi_ack
);
    // R3: read and I/O request strobes move as one
    a_r3_rd_iorq_paired: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n == iorq_n);

    // R3: read strobe is only active inside an opcode-fetch strobe
    a_r3_rd_inside_m1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !m1_n);

    // R2: opcode-fetch strobe leads the other two
    a_r2_m1_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m1_n) |-> (rd_n && iorq_n));

    // R6: processor is stalled whenever a strobe is active
    a_r6_stall_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_n |-> !cpu_ready);

    // R4: strobes release together with the identifier update
    a_r4_release_with_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (m1_n && ident_valid));

    // R5: identifier only changes when flagged valid
    a_r5_ident_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ident_word) |-> ident_valid);

    // R7: non-maskable flag never coincides with peripheral strobes
    a_r7_nmi_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |-> (m1_n && rd_n && iorq_n && cpu_ready));

    // R7: non-maskable flag lasts one cycle
    a_r7_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |=> !nmi_ack);
endmodule

bind viack_bridge viack_bridge_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .m1_n        (m1_n),
    .rd_n        (rd_n),
    .iorq_n      (iorq_n),
    .cpu_ready   (cpu_ready),
    .ident_word  (ident_word),
    .ident_valid (ident_valid),
    .nmi_ack     (nmi_ack)
);

// File: tb/viack_bridge_tb_top.sv
`timescale 1ns/1ps
module viack_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic [3:0]  txn_code = 4'h0;
    logic [7:0]  periph_data = 8'hEE;
    logic [7:0]  status_byte = 8'h00;
    logic        m1_n, rd_n, iorq_n, cpu_ready, ident_valid, nmi_ack;
    logic [15:0] ident_word;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] last_ident = 16'h0000;

    always #10 clk = ~clk;

    viack_bridge dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_valid   (txn_valid),
        .txn_code    (txn_code),
        .periph_data (periph_data),
        .status_byte (status_byte),
        .m1_n        (m1_n),
        .rd_n        (rd_n),
        .iorq_n      (iorq_n),
        .cpu_ready   (cpu_ready),
        .ident_word  (ident_word),
        .ident_valid (ident_valid),
        .nmi_ack     (nmi_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // strobes as {m1_n, rd_n, iorq_n}
    task automatic check_strobes(input string req, input logic [2:0] exp);
        check({m1_n, rd_n, iorq_n} === exp, req, "strobes", {m1_n, rd_n, iorq_n}, exp);
    endtask

    task automatic check_idle(input string req);
        check_strobes(req, 3'b111);
        check(cpu_ready === 1'b1, req, "cpu_ready", cpu_ready, 1);
        check(ident_valid === 1'b0, req, "ident_valid", ident_valid, 0);
        check(nmi_ack === 1'b0, req, "nmi_ack", nmi_ack, 0);
        check(ident_word === last_ident, req, "ident_word", ident_word, last_ident);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check_idle("R1");
        check(ident_word === 16'h0000, "R1", "ident_word", ident_word, 0);
    endtask

    // Full vectored acknowledge; optionally inject a code mid-handshake (R9)
    task automatic t_vi_ack(input logic [7:0] vec, input logic [7:0] stat,
                            input bit inject, input logic [3:0] inj_code);
        periph_data = 8'hEE;
        status_byte = ~stat;
        txn_code  = 4'b0111;
        txn_valid = 1'b1;
        @(negedge clk);               // after accept edge
        txn_valid = 1'b0;
        txn_code  = 4'h0;
        check_strobes("R2", 3'b011);
        check(cpu_ready === 1'b0, "R2", "cpu_ready", cpu_ready, 0);
        if (inject) begin
            txn_code  = inj_code;
            txn_valid = 1'b1;
        end
        @(negedge clk);               // window cycle 1
        txn_valid = 1'b0;
        txn_code  = 4'h0;
        check_strobes("R3", 3'b000);
        check(cpu_ready === 1'b0, "R6", "cpu_ready", cpu_ready, 0);
        check(nmi_ack === 1'b0, "R9", "nmi_ack", nmi_ack, 0);
        if (inject) begin
            txn_code  = inj_code;
            txn_valid = 1'b1;
        end
        @(negedge clk);               // window cycle 2
        txn_valid = 1'b0;
        txn_code  = 4'h0;
        check_strobes("R3", 3'b000);
        check(cpu_ready === 1'b0, "R6", "cpu_ready", cpu_ready, 0);
        check(ident_valid === 1'b0, "R4", "ident_valid early", ident_valid, 0);
        check(nmi_ack === 1'b0, "R9", "nmi_ack", nmi_ack, 0);
        periph_data = vec;
        status_byte = stat;
        @(negedge clk);               // after capture edge
        periph_data = 8'hEE;
        status_byte = 8'h00;
        check_strobes("R4", 3'b111);
        check(cpu_ready === 1'b1, "R6", "cpu_ready", cpu_ready, 1);
        check(ident_valid === 1'b1, "R5", "ident_valid", ident_valid, 1);
        check(ident_word === {stat, vec}, "R5", "ident_word", ident_word, {stat, vec});
        check(ident_word[7:0] === vec, "R10", "vector", ident_word[7:0], vec);
        last_ident = {stat, vec};
        @(negedge clk);
        check_idle(inject ? "R9" : "R5");
    endtask

    task automatic t_nmi();
        txn_code  = 4'b0101;
        txn_valid = 1'b1;
        @(negedge clk);
        txn_valid = 1'b0;
        check(nmi_ack === 1'b1, "R7", "nmi_ack", nmi_ack, 1);
        check_strobes("R7", 3'b111);
        check(cpu_ready === 1'b1, "R7", "cpu_ready", cpu_ready, 1);
        check(ident_word === last_ident, "R7", "ident_word", ident_word, last_ident);
        @(negedge clk);
        check_idle("R7");
    endtask

    task automatic t_other(input logic [3:0] code, input bit valid);
        txn_code  = code;
        txn_valid = valid;
        periph_data = 8'h99;
        @(negedge clk);
        txn_valid = 1'b0;
        check_idle("R8");
        @(negedge clk);
        check_idle("R8");
        @(negedge clk);
        check_idle("R8");
        txn_code = 4'h0;
        periph_data = 8'hEE;
    endtask

    initial begin
        t_reset();
        t_vi_ack(8'hA5, 8'h12, 1'b0, 4'h0);
        t_vi_ack(8'h5A, 8'h34, 1'b0, 4'h0);
        t_vi_ack(8'h00, 8'hFF, 1'b0, 4'h0);
        t_vi_ack(8'hFF, 8'h00, 1'b0, 4'h0);
        t_vi_ack(8'h3C, 8'h81, 1'b0, 4'h0);
        t_vi_ack(8'hC3, 8'h7E, 1'b0, 4'h0);
        t_vi_ack(8'h81, 8'hC9, 1'b0, 4'h0);
        t_vi_ack(8'h7E, 8'h66, 1'b0, 4'h0);
        t_nmi();
        t_other(4'b0110, 1'b1);   // non-vectored code
        t_other(4'b0011, 1'b1);   // unrelated code
        t_other(4'b0111, 1'b0);   // vectored code without valid
        t_vi_ack(8'h42, 8'h24, 1'b1, 4'b0101);  // NMI code mid-handshake
        t_vi_ack(8'h18, 8'hE7, 1'b1, 4'b0111);  // VI code mid-handshake
        t_nmi();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule